// File: doc/BRIEF.md
# Mask-Equation Tiled Metadata Address Generator

This block turns a pixel coordinate (x, y, slice) into the byte address of its compression or tile metadata. It also gives a nibble position inside that byte when the metadata is the packed 4-bit color-mask kind. The low part of the address comes from a programmable bit equation. Each equation bit is the parity of the coordinate bits picked out by four masks: one over x, one over y, one over the slice index, and one over a lane that is always zero. The remaining parts are a linear offset for the metadata block, a slice offset, and a pipe-select term. The pipe-select term is clipped so that it stays inside one metadata block.

The caller supplies the equation, the log2 sizes of the metadata block, a log2 element size and a pitch. It also supplies a slice size, the pipe-select value with its width, and an interleave step. A two-bit kind code picks how the in-block size exponent is formed:

- 0: per-pixel color compression, with the element size counted in.
- 1: depth tile info.
- 2: packed color mask.
- 3: not valid.

Requests enter with a valid strobe, one per cycle if wanted. Each result leaves exactly two cycles later. Mipmapped and multisampled surfaces are not handled.

Top module: `meta_addr_gen`

## Requirements
- R1: Equation bit i is the XOR of parity(x & Mx[i]), parity(y & My[i]), parity(z & Mz[i]) and parity(0 & M0[i]). The fourth mask therefore never changes the result. The mask for bit i, lane c (c = 0 x, 1 y, 2 z, 3 zero lane) sits at in_eq[(i*4+c)*16 +: 16].
- R2: Only equation bits 0 to S are used, where S is the size exponent. Higher equation bits have no effect on the address.
- R3: The size exponent S is set by the kind code. Kind 0 gives S = W + H + E - 8. Kind 1 gives S = W + H - 4. Kind 2 gives S = W + H - 7. Here W and H are the block width and height log2 and E is log2 of bytes per element.
- R4: The block index is (y >> H) * (pitch >> W) + (x >> W).
- R5: The pipe term is ((pipe_xor & (2^P - 1)) << (8 + I)) & (2^S - 1). P is the pipe-count log2 and I is the interleave step.
- R6: out_addr = slice_size*z + (block index << S) + ((equation value >> 1) XOR pipe term), taken modulo 2^32.
- R7: In kind 2, out_bit_pos = equation bit 0 times 4. In kinds 0 and 1 it is 0.
- R8: Kind 3 raises out_err, and out_addr and out_bit_pos are 0.
- R9: When S < 0 or S > 15, out_err is raised, and out_addr and out_bit_pos are 0.
- R10: A request accepted with in_valid at one rising edge shows out_valid and its result after the second rising edge. Back-to-back requests come out in order, one per cycle.
- R11: After reset, out_valid, out_err, out_addr and out_bit_pos are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 2 | Kind code: 0 color compression, 1 depth tile, 2 color mask, 3 not valid |
| in_eq | input | 1024 | Equation masks, 16 bits x 4 lanes x 16 equation bits |
| in_blk_w_log2 | input | 5 | Metadata block width log2 |
| in_blk_h_log2 | input | 5 | Metadata block height log2 |
| in_elem_log2 | input | 5 | log2 of bytes per element (kind 0 only) |
| in_pitch | input | 16 | Surface pitch in pixels |
| in_slice_size | input | 32 | Metadata bytes per slice |
| in_x | input | 16 | x coordinate |
| in_y | input | 16 | y coordinate |
| in_z | input | 16 | Slice index |
| in_pipe_xor | input | 8 | Pipe-select value |
| in_pipe_log2 | input | 4 | Number of pipe bits |
| in_ilv | input | 2 | Interleave step added to 8 |
| out_valid | output | 1 | Result strobe |
| out_addr | output | 32 | Metadata byte address |
| out_bit_pos | output | 3 | Nibble position within the byte (kind 2) |
| out_err | output | 1 | Invalid kind or size exponent out of range |

## Verification
A wrong size exponent moves every block offset by a power of two, so the address is visibly wrong in the same cycle its result is valid. A lost or extra stage-one valid shows up as out_valid landing one cycle early or late against the request. A pipe term that is not clipped leaks a bit above the block size into the address. All of these faults show at the ports in the second cycle after the request that triggers them. No state carries over from one request to the next, so a corrupted stage affects only the requests in flight at that moment.

// File: rtl/meta_addr_pkg.sv
// Shared constants and kind codes for the metadata address generator.
// Assumes two-bit kind codes; value 3 is not a valid kind.
package meta_addr_pkg;
    localparam int N_LANES = 4;      // x, y, z, constant-zero lane

    typedef enum logic [1:0] {
        KIND_CCOMP = 2'd0,
        KIND_DTILE = 2'd1,
        KIND_CMASK = 2'd2,
        KIND_BAD   = 2'd3
    } meta_kind_e;

    localparam int OFS_CCOMP = 8;
    localparam int OFS_DTILE = 4;
    localparam int OFS_CMASK = 7;
endpackage

// File: rtl/meta_eq_parity.sv
// Evaluates the masked-parity equation: every output bit is the parity of
// the coordinate bits its four lane masks select. Lane 3 carries zero.
// Assumes mask width equals coordinate width. Purely combinational.
module meta_eq_parity
    import meta_addr_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int EQ_BITS = 16,
    localparam int EQ_W   = EQ_BITS * N_LANES * COORD_W
) (
    input  logic [EQ_W-1:0]    eq_masks,
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    input  logic [COORD_W-1:0] z,
    output logic [EQ_BITS-1:0] eq_val
);
    logic [COORD_W-1:0] lane [N_LANES];
    logic [N_LANES-1:0] lane_par [EQ_BITS];

    assign lane[0] = x;
    assign lane[1] = y;
    assign lane[2] = z;
    assign lane[3] = '0;

    for (genvar i = 0; i < EQ_BITS; i++) begin : g_bit
        for (genvar c = 0; c < N_LANES; c++) begin : g_lane
            // parity of one lane under its mask
            assign lane_par[i][c] = ^(lane[c] & eq_masks[(i*N_LANES+c)*COORD_W +: COORD_W]);
        end
        // fold the lane parities into the equation bit
        assign eq_val[i] = ^lane_par[i];
    end
endmodule

// File: rtl/meta_blk_sizer.sv
// Derives the in-block size exponent from the kind code and block shape,
// and flags an invalid kind or an exponent outside 0..EQ_BITS-1.
// Assumes log2 inputs are small unsigned values. Combinational.
module meta_blk_sizer
    import meta_addr_pkg::*;
#(
    parameter int EQ_BITS = 16,
    parameter int LOG_W   = 5
) (
    input  logic [1:0]       mode,
    input  logic [LOG_W-1:0] w_log2,
    input  logic [LOG_W-1:0] h_log2,
    input  logic [LOG_W-1:0] elem_log2,
    output logic [LOG_W-1:0] blk_log2,
    output logic             err,
    output logic             is_cmask
);
    int sum;

    // select the per-kind formula and range-check the result
    always_comb begin
        sum      = int'(w_log2) + int'(h_log2);
        is_cmask = 1'b0;
        err      = 1'b0;
        case (meta_kind_e'(mode))
            KIND_CCOMP: sum = sum + int'(elem_log2) - OFS_CCOMP;
            KIND_DTILE: sum = sum - OFS_DTILE;
            KIND_CMASK: begin
                sum      = sum - OFS_CMASK;
                is_cmask = 1'b1;
            end
            default:    err = 1'b1;
        endcase
        if (sum < 0 || sum > EQ_BITS - 1) err = 1'b1;
        blk_log2 = err ? '0 : LOG_W'(sum);
    end
endmodule

// File: rtl/meta_lin_offset.sv
// Computes the linear block index inside a slice and the slice byte offset.
// Assumes power-of-two block sides given as log2; results wrap at ADDR_W.
module meta_lin_offset #(
    parameter int COORD_W = 16,
    parameter int ADDR_W  = 32,
    parameter int LOG_W   = 5
) (
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    input  logic [COORD_W-1:0] z,
    input  logic [COORD_W-1:0] pitch,
    input  logic [ADDR_W-1:0]  slice_size,
    input  logic [LOG_W-1:0]   w_log2,
    input  logic [LOG_W-1:0]   h_log2,
    output logic [ADDR_W-1:0]  blk_idx,
    output logic [ADDR_W-1:0]  slice_off
);
    logic [COORD_W-1:0] xb, yb, pb;

    // coordinates and pitch in block units
    always_comb begin
        xb = x >> w_log2;
        yb = y >> h_log2;
        pb = pitch >> w_log2;
    end

    // row-major block index and slice base
    always_comb begin
        blk_idx   = ADDR_W'(yb) * ADDR_W'(pb) + ADDR_W'(xb);
        slice_off = slice_size * ADDR_W'(z);
    end
endmodule

// File: rtl/meta_addr_gen.sv
// Top of the metadata address generator. Stage 1 registers the equation
// value, size exponent, block index, slice offset and clipped pipe term.
// Stage 2 sums them into the address. Latency is two cycles, one request
// per cycle. Assumes EQ_BITS <= ADDR_W and EQ_BITS <= 2**LOG_W.
module meta_addr_gen
    import meta_addr_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int EQ_BITS = 16,
    parameter int ADDR_W  = 32,
    parameter int LOG_W   = 5,
    parameter int PIPE_W  = 8,
    parameter int NPIPE_W = 4,
    parameter int ILV_W   = 2,
    localparam int EQ_W   = EQ_BITS * N_LANES * COORD_W,
    localparam int ILV_BASE = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         in_mode,
    input  logic [EQ_W-1:0]    in_eq,
    input  logic [LOG_W-1:0]   in_blk_w_log2,
    input  logic [LOG_W-1:0]   in_blk_h_log2,
    input  logic [LOG_W-1:0]   in_elem_log2,
    input  logic [COORD_W-1:0] in_pitch,
    input  logic [ADDR_W-1:0]  in_slice_size,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    input  logic [COORD_W-1:0] in_z,
    input  logic [PIPE_W-1:0]  in_pipe_xor,
    input  logic [NPIPE_W-1:0] in_pipe_log2,
    input  logic [ILV_W-1:0]   in_ilv,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_addr,
    output logic [2:0]         out_bit_pos,
    output logic               out_err
);
    logic [EQ_BITS-1:0] eq_raw, eq_keep;
    logic [LOG_W-1:0]   blk_log2;
    logic               blk_err, is_cmask;
    logic [ADDR_W-1:0]  blk_idx, slice_off, pipe_term;

    logic               s1_vld, s1_err, s1_cmask;
    logic [EQ_BITS-1:0] s1_eq;
    logic [LOG_W-1:0]   s1_blk;
    logic [ADDR_W-1:0]  s1_idx, s1_slice, s1_pt;

    meta_eq_parity #(.COORD_W(COORD_W), .EQ_BITS(EQ_BITS)) eq_i (
        .eq_masks(in_eq), .x(in_x), .y(in_y), .z(in_z), .eq_val(eq_raw)
    );

    meta_blk_sizer #(.EQ_BITS(EQ_BITS), .LOG_W(LOG_W)) sz_i (
        .mode(in_mode), .w_log2(in_blk_w_log2), .h_log2(in_blk_h_log2),
        .elem_log2(in_elem_log2), .blk_log2(blk_log2), .err(blk_err),
        .is_cmask(is_cmask)
    );

    meta_lin_offset #(.COORD_W(COORD_W), .ADDR_W(ADDR_W), .LOG_W(LOG_W)) lin_i (
        .x(in_x), .y(in_y), .z(in_z), .pitch(in_pitch),
        .slice_size(in_slice_size), .w_log2(in_blk_w_log2),
        .h_log2(in_blk_h_log2), .blk_idx(blk_idx), .slice_off(slice_off)
    );

    // keep equation bits 0..blk_log2 only
    always_comb begin
        for (int i = 0; i < EQ_BITS; i++) begin
            eq_keep[i] = eq_raw[i] && (i <= int'(blk_log2));
        end
    end

    // pipe-select term limited by pipe count and clipped to the block
    always_comb begin
        pipe_term = ADDR_W'(in_pipe_xor) & ((ADDR_W'(1) << in_pipe_log2) - ADDR_W'(1));
        pipe_term = pipe_term << (ILV_BASE + int'(in_ilv));
        pipe_term = pipe_term & ((ADDR_W'(1) << blk_log2) - ADDR_W'(1));
    end

    // stage 1: capture the partial results of an accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_err   <= 1'b0;
            s1_cmask <= 1'b0;
            s1_eq    <= '0;
            s1_blk   <= '0;
            s1_idx   <= '0;
            s1_slice <= '0;
            s1_pt    <= '0;
        end else begin
            s1_vld <= in_valid;
            if (in_valid) begin
                s1_err   <= blk_err;
                s1_cmask <= is_cmask;
                s1_eq    <= eq_keep;
                s1_blk   <= blk_log2;
                s1_idx   <= blk_idx;
                s1_slice <= slice_off;
                s1_pt    <= pipe_term;
            end
        end
    end

    // stage 2: combine the parts into the final address and nibble position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_err     <= 1'b0;
            out_addr    <= '0;
            out_bit_pos <= '0;
        end else begin
            out_valid <= s1_vld;
            out_err   <= s1_err;
            if (s1_err) begin
                out_addr    <= '0;
                out_bit_pos <= '0;
            end else begin
                out_addr    <= s1_slice + (s1_idx << s1_blk)
                             + (ADDR_W'(s1_eq >> 1) ^ s1_pt);
                out_bit_pos <= s1_cmask ? {s1_eq[0], 2'b00} : 3'd0;
            end
        end
    end

    // R10: an accepted request reaches stage 1 on the next edge
    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_vld);
    // R10: stage 1 always hands over to the output one edge later
    p_advance_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |=> out_valid);
    // R10: no output strobe without a request in stage 1
    p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_vld |=> !out_valid);
    // R9: a valid exponent stays within the equation length
    p_blk_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && !s1_err) |-> (int'(s1_blk) < EQ_BITS));
    // R2: no equation bit above the exponent survives stage 1
    p_eq_trunc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |-> (((ADDR_W'(s1_eq) >> s1_blk) >> 1) == '0));
    // R5: the pipe term never reaches past the block size
    p_pipe_clip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |-> ((s1_pt >> s1_blk) == '0));
    // R7: the nibble position is always a multiple of four
    p_bitpos_form_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_bit_pos[1:0] == 2'b00));
    // R8: an error result carries no address
    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_addr == '0 && out_bit_pos == 3'd0));
endmodule

// File: tb/meta_addr_gen_tb_top.sv
module meta_addr_gen_tb_top;
    localparam int CW = 16;
    localparam int EB = 16;

    typedef struct packed {
        logic [1:0]  mode;
        logic [4:0]  wl;
        logic [4:0]  hl;
        logic [4:0]  el;
        logic [15:0] x;
        logic [15:0] y;
        logic [15:0] z;
        logic [15:0] pitch;
        logic [31:0] slice;
        logic [7:0]  pxor;
        logic [3:0]  np;
        logic [1:0]  il;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 5'd6,  5'd5, 5'd2, 16'h1234, 16'h0567, 16'd1,    16'd256,  32'd4096,     8'h05, 4'd2, 2'd0},
        '{2'd0, 5'd8,  5'd6, 5'd4, 16'h03FF, 16'h002A, 16'd0,    16'd512,  32'd0,        8'h03, 4'd2, 2'd1},
        '{2'd1, 5'd7,  5'd7, 5'd0, 16'h0ABC, 16'h0123, 16'd3,    16'd1024, 32'd70000,    8'h07, 4'd3, 2'd0},
        '{2'd1, 5'd6,  5'd6, 5'd3, 16'h0F0F, 16'h00F1, 16'd2,    16'd320,  32'd1000,     8'h01, 4'd1, 2'd0},
        '{2'd2, 5'd7,  5'd6, 5'd0, 16'h0155, 16'h0033, 16'd5,    16'd640,  32'd2048,     8'h0F, 4'd4, 2'd2},
        '{2'd2, 5'd8,  5'd8, 5'd0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 32'hFFFFFFFF, 8'hFF, 4'd8, 2'd0},
        '{2'd0, 5'd8,  5'd8, 5'd4, 16'h7777, 16'h1EE1, 16'd7,    16'd2048, 32'd123456,   8'hFF, 4'd4, 2'd3},
        '{2'd1, 5'd10, 5'd9, 5'd0, 16'hC0DE, 16'hBEEF, 16'd9,    16'd4096, 32'd65536,    8'h2D, 4'd6, 2'd1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [1:0]        in_mode = '0;
    logic [EB*4*CW-1:0] in_eq = '0;
    logic [4:0]        in_blk_w_log2 = '0, in_blk_h_log2 = '0, in_elem_log2 = '0;
    logic [15:0]       in_pitch = '0, in_x = '0, in_y = '0, in_z = '0;
    logic [31:0]       in_slice_size = '0;
    logic [7:0]        in_pipe_xor = '0;
    logic [3:0]        in_pipe_log2 = '0;
    logic [1:0]        in_ilv = '0;
    logic              out_valid, out_err;
    logic [31:0]       out_addr;
    logic [2:0]        out_bit_pos;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    meta_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_eq(in_eq), .in_blk_w_log2(in_blk_w_log2),
        .in_blk_h_log2(in_blk_h_log2), .in_elem_log2(in_elem_log2),
        .in_pitch(in_pitch), .in_slice_size(in_slice_size), .in_x(in_x),
        .in_y(in_y), .in_z(in_z), .in_pipe_xor(in_pipe_xor),
        .in_pipe_log2(in_pipe_log2), .in_ilv(in_ilv), .out_valid(out_valid),
        .out_addr(out_addr), .out_bit_pos(out_bit_pos), .out_err(out_err)
    );

    function automatic logic [15:0] msk(input logic [EB*4*CW-1:0] eq, input int i, input int c);
        return eq[(i*4+c)*CW +: CW];
    endfunction

    // bench equation: x bits low, y bits high, plus cross terms
    function automatic logic [EB*4*CW-1:0] build_eq(input bit zero_lane);
        logic [EB*4*CW-1:0] e = '0;
        for (int i = 0; i < EB; i++) begin
            logic [15:0] mx, my, mz, m0;
            mx = (i < 8) ? 16'(1 << i) : 16'h0;
            my = (i >= 8) ? 16'(1 << (i - 8)) : 16'h0;
            mz = 16'h0;
            m0 = 16'h0;
            if (i == 0) mx = mx | 16'h0200;
            if (i == 3) my = my | 16'h0001;
            if (i == 5) mz = 16'h0001;
            if (i == 1 && !zero_lane) m0 = 16'hFFFF;
            e[(i*4+0)*CW +: CW] = mx;
            e[(i*4+1)*CW +: CW] = my;
            e[(i*4+2)*CW +: CW] = mz;
            e[(i*4+3)*CW +: CW] = m0;
        end
        return e;
    endfunction

    // model from the requirements: returns {err, bitpos, addr}
    function automatic logic [35:0] model(input vec_t v, input logic [EB*4*CW-1:0] eq);
        int s;
        logic [31:0] e, idx, pt, a;
        logic [15:0] zero16;
        s = int'(v.wl) + int'(v.hl);
        case (v.mode)
            2'd0: s = s + int'(v.el) - 8;
            2'd1: s = s - 4;
            2'd2: s = s - 7;
            default: return {1'b1, 3'd0, 32'd0};
        endcase
        if (s < 0 || s > EB - 1) return {1'b1, 3'd0, 32'd0};
        zero16 = 16'h0;
        e = 0;
        for (int i = 0; i <= s; i++)
            e[i] = (^(v.x & msk(eq, i, 0))) ^ (^(v.y & msk(eq, i, 1)))
                 ^ (^(v.z & msk(eq, i, 2))) ^ (^(zero16 & msk(eq, i, 3)));
        idx = 32'(v.y >> v.hl) * 32'(v.pitch >> v.wl) + 32'(v.x >> v.wl);
        pt = (32'(v.pxor) & ((32'd1 << v.np) - 1)) << (8 + int'(v.il));
        pt = pt & ((32'd1 << s) - 1);
        a = v.slice * 32'(v.z) + (idx << s) + ((e >> 1) ^ pt);
        return {1'b0, (v.mode == 2'd2) ? {e[0], 2'b00} : 3'd0, a};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        in_mode = v.mode; in_blk_w_log2 = v.wl; in_blk_h_log2 = v.hl;
        in_elem_log2 = v.el; in_x = v.x; in_y = v.y; in_z = v.z;
        in_pitch = v.pitch; in_slice_size = v.slice; in_pipe_xor = v.pxor;
        in_pipe_log2 = v.np; in_ilv = v.il;
    endtask

    // drive one request at a negedge, sample two edges later
    task automatic run_one(input vec_t v, input string req, input logic [35:0] exp);
        @(negedge clk);
        apply(v);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " no early valid"}, 32'(out_valid), 32'd0);
        @(negedge clk);
        chk({req, " valid"}, 32'(out_valid), 32'd1);
        chk({req, " addr"}, out_addr, exp[31:0]);
        chk({req, " bitpos"}, 32'(out_bit_pos), 32'(exp[34:32]));
        chk({req, " err"}, 32'(out_err), 32'(exp[35]));
    endtask

    initial begin
        vec_t d;
        logic [35:0] ea, eb;
        in_eq = build_eq(1'b0);
        repeat (3) @(negedge clk);
        // R11: reset values
        chk("R11 valid", 32'(out_valid), 32'd0);
        chk("R11 addr", out_addr, 32'd0);
        chk("R11 bitpos/err", {28'd0, out_bit_pos, out_err}, 32'd0);
        rst_n = 1'b1;

        // table walk: R3 R4 R5 R6 R7 across kinds
        for (int k = 0; k < 8; k++) begin
            run_one(VECS[k], $sformatf("R6 vec%0d", k), model(VECS[k], in_eq));
        end

        // R2/R4/R1: depth tile, S=4, x bits above S set; hand value 381
        d = '{2'd1, 5'd4, 5'd4, 5'd0, 16'h00F3, 16'h0021, 16'd0, 16'd64, 32'd0, 8'h00, 4'd0, 2'd0};
        run_one(d, "R2 R4 hand", {1'b0, 3'd0, 32'd381});
        // R1: clearing the zero-lane mask leaves the result unchanged
        in_eq = build_eq(1'b1);
        run_one(d, "R1 zero lane", {1'b0, 3'd0, 32'd381});
        in_eq = build_eq(1'b0);
        // R6: slice offset only, z=2, slice=1000 -> 2000
        d = '{2'd1, 5'd4, 5'd4, 5'd0, 16'h0000, 16'h0000, 16'd2, 16'd64, 32'd1000, 8'h00, 4'd0, 2'd0};
        run_one(d, "R6 slice", {1'b0, 3'd0, 32'd2000});
        // R7/R5: color mask S=1, x=3 -> addr 1, nibble 4, pipe clipped away
        d = '{2'd2, 5'd4, 5'd4, 5'd0, 16'h0003, 16'h0000, 16'd0, 16'd64, 32'd0, 8'hFF, 4'd8, 2'd0};
        run_one(d, "R7 R5 cmask", {1'b0, 3'd4, 32'd1});
        // R7: same in depth-tile kind gives nibble 0
        d.mode = 2'd1; d.wl = 5'd2; d.hl = 5'd3;
        run_one(d, "R7 non-cmask", {1'b0, 3'd0, 32'd1});
        // R5: S=9, pipe 3 limited to one bit -> 0x100
        d = '{2'd0, 5'd8, 5'd5, 5'd4, 16'h0000, 16'h0000, 16'd0, 16'd256, 32'd0, 8'h03, 4'd1, 2'd0};
        run_one(d, "R5 pipe", {1'b0, 3'd0, 32'd256});
        // R3: element size ignored outside kind 0
        d = '{2'd1, 5'd4, 5'd4, 5'd9, 16'h00F3, 16'h0021, 16'd0, 16'd64, 32'd0, 8'h00, 4'd0, 2'd0};
        run_one(d, "R3 elem ignored", {1'b0, 3'd0, 32'd381});
        // R8: kind 3
        d.mode = 2'd3;
        run_one(d, "R8 bad kind", {1'b1, 3'd0, 32'd0});
        // R9: negative exponent (2+2-7) and too large (10+10-4)
        d = '{2'd2, 5'd2, 5'd2, 5'd0, 16'h0013, 16'h0005, 16'd1, 16'd64, 32'd77, 8'h00, 4'd0, 2'd0};
        run_one(d, "R9 low", {1'b1, 3'd0, 32'd0});
        d.mode = 2'd1; d.wl = 5'd10; d.hl = 5'd10;
        run_one(d, "R9 high", {1'b1, 3'd0, 32'd0});

        // R10: two back-to-back requests come out on consecutive cycles
        ea = model(VECS[2], in_eq);
        eb = model(VECS[4], in_eq);
        @(negedge clk);
        apply(VECS[2]); in_valid = 1'b1;
        @(negedge clk);
        apply(VECS[4]);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 first valid", 32'(out_valid), 32'd1);
        chk("R10 first addr", out_addr, ea[31:0]);
        @(negedge clk);
        chk("R10 second valid", 32'(out_valid), 32'd1);
        chk("R10 second addr", out_addr, eb[31:0]);
        @(negedge clk);
        chk("R10 drained", 32'(out_valid), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule